// File: doc/BRIEF.md
# Prescaled Timer/Counter with Write-Masked Compare Matches

This block is a counter that advances on a prescaled tick and runs either as a single 16-bit counter or, using only its low byte, as an 8-bit counter. Two compare registers (A and B) are checked against the count. Each one raises its own flag on a match. An overflow flag marks the tick on which the counter sits at its maximum value. Every flag drives an interrupt request through its own enable bit. A flag is cleared either by the acknowledge input for that flag or by writing a one to its bit.

Software reaches everything through a byte-wide register port with a one-cycle write strobe and a combinational read. Any write to either counter byte suppresses all compare matches on the next tick that follows. This lets software load the counter with a compare value without raising a spurious flag, and it holds even when no tick arrives for many cycles. The 16-bit count is loaded in one step: the high byte is staged first, and the low-byte write commits both bytes.

Register addresses: 0 count low, 1 count high, 2 compare A low, 3 compare A high, 4 compare B, 5 mode, 6 flags, 7 interrupt enables.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads as zero and all three interrupt requests are low.
- R2: The count changes only on a cycle with `tick_en` high or a count-low write. In 8-bit modes (mode bit 0 = 0), each tick adds one to the low byte, the low byte wraps from 0xFF to 0x00, and the high byte is left unchanged.
- R3: In 16-bit mode (mode bit 0 = 1), each tick adds one to the full count, which wraps from 0xFFFF to 0x0000.
- R4: In the clear-on-compare mode (mode bits: bit 2 = 1, bit 1 = 0, bit 0 = 0), a tick while the low byte equals compare A low loads the low byte with 0x00.
- R5: The overflow flag (flags bit 2) is set by a tick taken while the count is at its maximum: low byte 0xFF in 8-bit modes, 0xFFFF in 16-bit mode.
- R6: A tick taken while the count equals a compare register sets that register's flag (A is bit 0, B is bit 1). In 8-bit modes, the low byte is compared against compare A low and against compare B. In 16-bit mode, all 16 bits are compared against compare A.
- R7: In 16-bit mode, flag B is never set.
- R8: A write to address 0 or 1 blocks both compare flags on the next tick after it, however many tick-free cycles come in between. The tick after that is not blocked.
- R9: If the count is written with a value equal to a compare register, that match is lost and its flag stays clear.
- R10: A write to address 1 only stages the high byte and leaves the count unchanged. A write to address 0 loads the count with the staged high byte and the written low byte.
- R11: Writing to address 6 clears each flag whose data bit is one and leaves flags whose data bit is zero unchanged.
- R12: Bit i of `irq_ack` clears flag i only, and has no effect on the other flags.
- R13: `irq_req[i]` is high exactly when flag i and enable bit i (address 7) are both set.
- R14: Compare writes take effect at once: the next read returns the new value, and the new value is used on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Prescaled timer tick enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on address) |
| irq_ack | input | 3 | Per-flag interrupt acknowledge: bit 0 compare A, bit 1 compare B, bit 2 overflow |
| irq_req | output | 3 | Per-flag interrupt request, same bit order |

## Verification
Directed sequences cover the main tick counting cases. A plain count up to a compare value shows that matches are raised. A count loaded equal to a compare value shows that the write mask works. A tick held off for many cycles after a write shows that the mask waits for the next tick and is not a fixed cycle delay. Runs across the 8-bit wrap, the 16-bit wrap and the clear-on-compare limit tell the three counting modes apart. A long random phase then mixes ticks, writes to any register, acknowledges and mode changes. In that phase, writes and ticks in the same cycle test how count loads, flag sets and flag clears are ordered.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_W  = 16;
  localparam int HALF_W = TMR_W / 2;
  localparam int ADDR_W = 3;
  localparam int N_REG  = 2 ** ADDR_W;
  localparam int N_CMP  = 2;
  localparam int N_FLAG = N_CMP + 1;

  localparam int F_CMPA = 0;
  localparam int F_CMPB = 1;
  localparam int F_OVF  = 2;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CA_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CA_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CB     = 3'd4;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd6;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd7;

  typedef logic [TMR_W-1:0]  cnt_t;
  typedef logic [HALF_W-1:0] byte_t;

  // bit 0 wide, bit 1 capture enable, bit 2 clear-on-compare
  typedef struct packed {
    logic ctc;
    logic cap;
    logic wide;
  } mode_t;

  function automatic logic ctc_active(mode_t m);
    return !m.wide && !m.cap && m.ctc;
  endfunction

  function automatic logic at_max(cnt_t c, logic wide);
    return wide ? (&c) : (&c[HALF_W-1:0]);
  endfunction

  function automatic logic cmp_equal(cnt_t c, cnt_t r, logic wide);
    return wide ? (c == r) : (c[HALF_W-1:0] == r[HALF_W-1:0]);
  endfunction

  function automatic cnt_t next_count(cnt_t c, mode_t m, byte_t top);
    cnt_t n;
    n = c;
    if (m.wide)
      n = c + cnt_t'(1);
    else if (ctc_active(m) && (c[HALF_W-1:0] == top))
      n[HALF_W-1:0] = '0;
    else
      n[HALF_W-1:0] = c[HALF_W-1:0] + byte_t'(1);
    return n;
  endfunction
endpackage

// File: rtl/tmr_bus.sv
module tmr_bus import tmr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  input  cnt_t              cnt_q,
  input  logic [N_FLAG-1:0] flags,
  output byte_t             rdata,
  output logic              cnt_load,
  output logic              cnt_touch,
  output cnt_t              load_val,
  output cnt_t              cmp_a,
  output byte_t             cmp_b,
  output mode_t             mode,
  output logic [N_FLAG-1:0] ien,
  output logic [N_FLAG-1:0] w1c
);
  logic [N_REG-1:0] wsel;
  byte_t            hi_stage;

  assign wsel      = wr_en ? (N_REG'(1) << addr) : '0;
  assign cnt_load  = wsel[A_CNT_LO];
  assign cnt_touch = wsel[A_CNT_LO] | wsel[A_CNT_HI];
  assign load_val  = {hi_stage, wdata};
  assign w1c       = wsel[A_FLAGS] ? wdata[N_FLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_stage <= '0;
      cmp_a    <= '0;
      cmp_b    <= '0;
      mode     <= '0;
      ien      <= '0;
    end else begin
      if (wsel[A_CNT_HI]) hi_stage <= wdata;
      if (wsel[A_CA_LO])  cmp_a[HALF_W-1:0] <= wdata;
      if (wsel[A_CA_HI])  cmp_a[TMR_W-1:HALF_W] <= wdata;
      if (wsel[A_CB])     cmp_b <= wdata;
      if (wsel[A_MODE])   mode <= mode_t'(wdata[$bits(mode_t)-1:0]);
      if (wsel[A_IEN])    ien <= wdata[N_FLAG-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CNT_LO: rdata = cnt_q[HALF_W-1:0];
      A_CNT_HI: rdata = cnt_q[TMR_W-1:HALF_W];
      A_CA_LO:  rdata = cmp_a[HALF_W-1:0];
      A_CA_HI:  rdata = cmp_a[TMR_W-1:HALF_W];
      A_CB:     rdata = cmp_b;
      A_MODE:   rdata[$bits(mode_t)-1:0] = mode;
      A_FLAGS:  rdata[N_FLAG-1:0] = flags;
      default:  rdata[N_FLAG-1:0] = ien;
    endcase
  end

  // R14: compare registers load on the write edge, no shadow stage
  a_r14_cmpb_now: assert property (@(posedge clk) disable iff (!rst_n)
    wsel[A_CB] |=> cmp_b == $past(wdata));
  a_r14_cmpa_now: assert property (@(posedge clk) disable iff (!rst_n)
    wsel[A_CA_LO] |=> cmp_a[HALF_W-1:0] == $past(wdata));
endmodule

// File: rtl/tmr_core.sv
module tmr_core import tmr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  mode_t             mode,
  input  cnt_t              cmp_a,
  input  byte_t             cmp_b,
  input  logic              cnt_load,
  input  logic              cnt_touch,
  input  cnt_t              load_val,
  output cnt_t              cnt_q,
  output logic              blk_pend,
  output logic [N_FLAG-1:0] evt
);
  cnt_t cmp_vec [N_CMP];

  assign cmp_vec[0] = cmp_a;
  assign cmp_vec[1] = {{(TMR_W-HALF_W){1'b0}}, cmp_b};

  for (genvar g = 0; g < N_CMP; g++) begin : g_unit
    localparam bit WIDE_OK = (g == 0);
    logic unit_on;
    logic eq;
    assign unit_on = WIDE_OK || !mode.wide;
    assign eq      = cmp_equal(cnt_q, cmp_vec[g], mode.wide);
    assign evt[g]  = tick_en && !blk_pend && unit_on && eq;
  end

  assign evt[F_OVF] = tick_en && at_max(cnt_q, mode.wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          blk_pend <= 1'b0;
    else if (cnt_touch)  blk_pend <= 1'b1;
    else if (tick_en)    blk_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (cnt_load)  cnt_q <= load_val;
    else if (tick_en)   cnt_q <= next_count(cnt_q, mode, cmp_a[HALF_W-1:0]);
  end

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_load) |=> $stable(cnt_q));
  a_r2_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.wide && !cnt_load) |=> cnt_q[TMR_W-1:HALF_W] == $past(cnt_q[TMR_W-1:HALF_W]));
  a_r3_wrap16: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.wide && tick_en && !cnt_load && (&cnt_q)) |=> cnt_q == '0);
  a_r4_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc_active(mode) && tick_en && !cnt_load && cnt_q[HALF_W-1:0] == cmp_a[HALF_W-1:0])
      |=> cnt_q[HALF_W-1:0] == '0);
  a_r8_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_touch |=> blk_pend);
  a_r8_pend_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_pend && tick_en && !cnt_touch) |=> !blk_pend);
  a_r10_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_touch && !cnt_load && !tick_en) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags import tmr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FLAG-1:0] evt,
  input  logic [N_FLAG-1:0] ack,
  input  logic [N_FLAG-1:0] w1c,
  input  logic [N_FLAG-1:0] ien,
  output logic [N_FLAG-1:0] flags,
  output logic [N_FLAG-1:0] irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~(ack | w1c)) | evt;
  end

  assign irq = flags & ien;

  for (genvar i = 0; i < N_FLAG; i++) begin : g_chk
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
    a_r12_ack_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !evt[i]) |=> !flags[i]);
    a_r11_w1c_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c[i] && !evt[i]) |=> !flags[i]);
    a_r11_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[i] && !ack[i] && !w1c[i]) |=> flags[i] == $past(flags[i]));
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer import tmr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  input  logic [N_FLAG-1:0] irq_ack,
  output logic [N_FLAG-1:0] irq_req
);
  cnt_t              cnt_q;
  cnt_t              load_val;
  cnt_t              cmp_a;
  byte_t             cmp_b;
  mode_t             mode;
  logic              cnt_load;
  logic              cnt_touch;
  logic              blk_pend;
  logic [N_FLAG-1:0] ien;
  logic [N_FLAG-1:0] w1c;
  logic [N_FLAG-1:0] evt;
  logic [N_FLAG-1:0] flags;

  tmr_bus u_bus (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cnt_q(cnt_q), .flags(flags), .rdata(bus_rdata), .cnt_load(cnt_load),
    .cnt_touch(cnt_touch), .load_val(load_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .mode(mode), .ien(ien), .w1c(w1c)
  );

  tmr_core u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode(mode), .cmp_a(cmp_a),
    .cmp_b(cmp_b), .cnt_load(cnt_load), .cnt_touch(cnt_touch), .load_val(load_val),
    .cnt_q(cnt_q), .blk_pend(blk_pend), .evt(evt)
  );

  tmr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ack(irq_ack), .w1c(w1c), .ien(ien),
    .flags(flags), .irq(irq_req)
  );

  a_r5_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (mode.wide ? (&cnt_q) : (&cnt_q[HALF_W-1:0]))) |=> flags[F_OVF]);
  a_r7_no_cmpb: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.wide && !flags[F_CMPB]) |=> !flags[F_CMPB]);
  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_pend && tick_en && flags[F_CMPB:F_CMPA] == '0) |=> flags[F_CMPB:F_CMPA] == '0);
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/100ps
module sim_tick_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [2:0] irq_ack;
  logic [2:0] irq_req;

  always #2 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [15:0] m_cnt, m_ca;
  logic [7:0]  m_stage, m_cb;
  logic [2:0]  m_mode, m_flg, m_en;
  bit          m_blk;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_cnt[7:0];
      3'd1: return m_cnt[15:8];
      3'd2: return m_ca[7:0];
      3'd3: return m_ca[15:8];
      3'd4: return m_cb;
      3'd5: return {5'd0, m_mode};
      3'd6: return {5'd0, m_flg};
      default: return {5'd0, m_en};
    endcase
  endfunction

  task automatic model_step();
    bit wide, ctc_on, hit_a, hit_b, ovf;
    int lo;
    logic [2:0]  clr, setv;
    logic [15:0] ncnt;
    wide   = m_mode[0];
    ctc_on = (m_mode == 3'b100);
    hit_a  = wide ? (m_cnt == m_ca) : (m_cnt[7:0] == m_ca[7:0]);
    hit_b  = !wide && (m_cnt[7:0] == m_cb);
    ovf    = wide ? (m_cnt == 16'hFFFF) : (m_cnt[7:0] == 8'hFF);
    setv   = {tick_en && ovf, tick_en && !m_blk && hit_b, tick_en && !m_blk && hit_a};
    clr    = irq_ack | ((bus_wr && bus_addr == 3'd6) ? bus_wdata[2:0] : 3'd0);
    ncnt   = m_cnt;
    if (bus_wr && bus_addr == 3'd0) ncnt = {m_stage, bus_wdata};
    else if (tick_en) begin
      if (wide) ncnt = 16'((int'(m_cnt) + 1) % 65536);
      else begin
        lo = int'(m_cnt[7:0]);
        if (ctc_on && m_cnt[7:0] == m_ca[7:0]) lo = 0;
        else lo = (lo + 1) % 256;
        ncnt = {m_cnt[15:8], 8'(lo)};
      end
    end
    if (bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd1)) m_blk = 1;
    else if (tick_en) m_blk = 0;
    if (bus_wr) begin
      case (bus_addr)
        3'd1: m_stage = bus_wdata;
        3'd2: m_ca[7:0] = bus_wdata;
        3'd3: m_ca[15:8] = bus_wdata;
        3'd4: m_cb = bus_wdata;
        3'd5: m_mode = bus_wdata[2:0];
        3'd7: m_en = bus_wdata[2:0];
        default: ;
      endcase
    end
    m_flg = (m_flg & ~clr) | setv;
    m_cnt = ncnt;
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    chk("R13 irq_req vs model", {13'd0, irq_req}, {13'd0, m_flg & m_en});
    chk("R14 bus_rdata vs model", {8'd0, bus_rdata}, {8'd0, m_read(bus_addr)});
  endtask

  task automatic idle();
    tick_en = 0; bus_wr = 0; irq_ack = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 0;
  endtask

  task automatic tk(int n);
    tick_en = 1;
    for (int i = 0; i < n; i++) cyc();
    tick_en = 0;
  endtask

  task automatic rd(logic [2:0] a, string tag, logic [7:0] exp);
    bus_addr = a;
    cyc();
    chk(tag, {8'd0, bus_rdata}, {8'd0, exp});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); bus_addr = 0; bus_wdata = 0;
    m_cnt = 0; m_ca = 0; m_stage = 0; m_cb = 0; m_mode = 0; m_flg = 0; m_en = 0; m_blk = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();

    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset register", 8'h00);
    chk("R1 reset irq", {13'd0, irq_req}, 16'd0);

    // R2 / R6 / R12 / R11 basic 8-bit counting and flags
    wr(3'd7, 8'h07);
    wr(3'd2, 8'h05);
    wr(3'd4, 8'h03);
    wr(3'd0, 8'h00);
    tk(4);
    rd(3'd0, "R2 count after four ticks", 8'h04);
    rd(3'd6, "R6 compare B flag", 8'h02);
    irq_ack = 3'b010; cyc(); irq_ack = 0;
    rd(3'd6, "R12 ack clears only B", 8'h00);
    tk(2);
    rd(3'd6, "R6 compare A flag", 8'h01);
    irq_ack = 3'b110; cyc(); irq_ack = 0;
    rd(3'd6, "R12 ack of other flags leaves A", 8'h01);
    wr(3'd6, 8'h02);
    rd(3'd6, "R11 zero bit leaves flag", 8'h01);
    wr(3'd6, 8'h01);
    rd(3'd6, "R11 one bit clears flag", 8'h00);

    // R10 staged high byte, R2 8-bit wrap, R5 overflow
    wr(3'd1, 8'hAB);
    rd(3'd1, "R10 high write alone keeps count", 8'h00);
    rd(3'd0, "R10 low byte untouched", 8'h06);
    wr(3'd0, 8'hFE);
    rd(3'd1, "R10 low write commits staged high", 8'hAB);
    tk(2);
    rd(3'd0, "R2 low byte wrapped", 8'h00);
    rd(3'd1, "R2 high byte held in 8-bit", 8'hAB);
    rd(3'd6, "R5 overflow in 8-bit", 8'h04);

    // R3 / R5 / R7 / R6 16-bit mode
    wr(3'd6, 8'h07);
    wr(3'd5, 8'h01);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hFE);
    tk(2);
    rd(3'd0, "R3 wrap low", 8'h00);
    rd(3'd1, "R3 wrap high", 8'h00);
    rd(3'd6, "R5 overflow in 16-bit", 8'h04);
    wr(3'd6, 8'h04);
    tk(6);
    rd(3'd6, "R7 B silent, A full match", 8'h01);
    wr(3'd3, 8'h01);
    wr(3'd6, 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    tk(8);
    rd(3'd6, "R6 16-bit compare uses high byte", 8'h00);

    // R4 clear-on-compare mode
    wr(3'd5, 8'h04);
    wr(3'd2, 8'h04);
    wr(3'd0, 8'h00);
    tk(5);
    rd(3'd0, "R4 cleared at compare A", 8'h00);
    rd(3'd6, "R4 A and B flags", 8'h03);
    wr(3'd6, 8'h07);

    // R9 load equal to compare
    wr(3'd5, 8'h00);
    wr(3'd2, 8'h10);
    wr(3'd0, 8'h10);
    tk(1);
    rd(3'd6, "R9 match lost after load", 8'h00);

    // R8 block waits for the next tick while stopped
    wr(3'd4, 8'h20);
    wr(3'd0, 8'h20);
    repeat (10) cyc();
    tk(1);
    rd(3'd6, "R8 block across stopped cycles", 8'h00);
    rd(3'd0, "R8 count advanced", 8'h21);
    wr(3'd0, 8'h1F);
    tk(2);
    rd(3'd6, "R8 second tick not blocked", 8'h02);

    // R13 enable gating
    wr(3'd7, 8'h00);
    chk("R13 masked request", {13'd0, irq_req}, 16'd0);
    wr(3'd7, 8'h02);
    chk("R13 enabled request", {13'd0, irq_req}, 16'h0002);

    // R14 immediate compare update
    wr(3'd2, 8'h33);
    rd(3'd2, "R14 compare A readback", 8'h33);
    wr(3'd6, 8'h07);
    wr(3'd0, 8'h40);
    tk(1);
    wr(3'd4, 8'h41);
    tk(1);
    rd(3'd6, "R14 new compare B used next tick", 8'h02);

    // random mix, compared against the model every clock
    for (int i = 0; i < 4000; i++) begin
      tick_en   = ($urandom % 3) != 0;
      bus_wr    = ($urandom % 4) == 0;
      bus_addr  = 3'($urandom % 8);
      bus_wdata = 8'($urandom % 256);
      if (bus_wr && bus_addr == 3'd0 && ($urandom % 2) == 1) bus_wdata = 8'hFD;
      irq_ack   = (($urandom % 4) == 0) ? 3'($urandom % 8) : 3'd0;
      cyc();
    end
    idle();
    cyc();

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule